// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block loads a configuration bitstream into a target FPGA through an 8-bit parallel slave port. A load starts with a reset pulse on the target's program line. The block then waits for the target to finish clearing its memory. Next it raises the write and chip-select strobes and streams the bytes it takes from a valid/ready input. The target captures each byte on a rising edge of the configuration clock. After the last byte, the block keeps clocking the target until the target reports that configuration is complete.

While the target is stalled, the loader can re-clock the byte it is holding, and each wait phase has its own timeout. A failed phase releases the strobes and leaves a sticky reason code. The same port can also read a given number of bytes back from the target. The width of the clock's low and high phases is programmable, so the port can run below its fastest rate.

Top module: `cfg_loader_par`

## Requirements
- R1: After reset, program, chip select, write and input ready are low, the error code is 0 and the block is not active.
- R2: A load (start_i pulsed while idle) first drives prog_o high for half_per_i+1 cycles, with chip select and write low. It then releases prog_o.
- R3: After prog_o is released, no strobe rises until init_i and busy_i are both low. If they are still not both low TMO_CYC cycles after that phase begins, the load aborts with error code 1.
- R4: Write rises before chip select. s_ready_o is high only while chip select and write are both high and the clock is high.
- R5: Each accepted byte is held on d_o through a low clock phase and the following rising edge. The target receives exactly byte_cnt_i bytes, in order.
- R6: When busy_chk_en_i is 1 and busy_i is high at the end of a high clock phase, the block adds another clock pulse with the same byte. When busy_chk_en_i is 0, busy_i is ignored during streaming.
- R7: If busy_i stays high for TMO_CYC cycles, counted from the acceptance of the byte, the load aborts with error code 2.
- R8: After the last byte, chip select falls before write.
- R9: After the strobes drop, the block issues clock pulses until done_i is high, then pulses ok_o.
- R10: If done_i has not come TMO_CYC cycles after the completion wait begins, the load aborts with error code 3.
- R11: An abort drops chip select and write and pulses fail_o. The code (1 init, 2 busy, 3 done) stays on err_o until the next start or readback.
- R12: A readback (rdbk_i pulsed while idle) raises chip select with write and d_oe_o low. After each low-then-high clock pulse it captures d_i onto rd_data_o with rd_valid_o. It stops after byte_cnt_i bytes and pulses ok_o.
- R13: A byte count of 0 accepts no input bytes on a load and returns no bytes on a readback. No operation takes input bytes beyond its count.
- R14: Every low clock phase lasts exactly half_per_i+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (sampled while idle) |
| rdbk_i | input | 1 | Start a readback (sampled while idle; start_i wins) |
| byte_cnt_i | input | CNT_W | Number of bytes to load or read back |
| half_per_i | input | HP_W | Clock phase length minus one, in system cycles |
| busy_chk_en_i | input | 1 | Enable re-clocking while the target is busy |
| s_data_i | input | 8 | Input byte stream data |
| s_valid_i | input | 1 | Input byte valid |
| s_ready_o | output | 1 | Input byte ready |
| prog_o | output | 1 | Target program (reset) line, active high |
| cs_o | output | 1 | Target chip select, active high |
| wr_o | output | 1 | Target write strobe, active high |
| cclk_o | output | 1 | Target configuration clock |
| d_o | output | 8 | Data bus toward the target |
| d_oe_o | output | 1 | Data bus output enable |
| d_i | input | 8 | Data bus from the target |
| init_i | input | 1 | Target still initialising |
| busy_i | input | 1 | Target busy |
| done_i | input | 1 | Target configured |
| rd_data_o | output | 8 | Readback byte |
| rd_valid_o | output | 1 | Readback byte valid |
| active_o | output | 1 | Operation in progress |
| ok_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| err_o | output | 2 | Sticky failure code |

## Verification
The bench sweeps phase lengths and byte counts and models a target that stalls, holds init or never completes. A design that advanced past a busy edge would lose a byte or show too few clock edges. One that took a byte too many, or any byte at a count of zero, would show the wrong count of accepted input. Strobe order and the length of each low phase are measured at the pins, so a swapped drop order or an off-by-one pacer is visible. After each kind of timeout, the bench checks the error code, the released strobes and that the code persists. Without this, an abort that left chip select high or cleared its code would pass unnoticed.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_PROG, ST_W_INIT, ST_S_WR, ST_S_CS, ST_S_CLK, ST_STREAM,
    ST_C_LO, ST_C_HI, ST_E_CS, ST_E_WR, ST_DN_CHK, ST_DN_LO, ST_DN_HI,
    ST_ABORT, ST_RB_CS, ST_RB_LO, ST_RB_HI, ST_RB_END
  } ld_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_INIT = 2'd1,
    ERR_BUSY = 2'd2,
    ERR_DONE = 2'd3
  } ld_err_e;
endpackage

// File: rtl/cfg_ld_pacer.sv
module cfg_ld_pacer #(
  parameter int HP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic [HP_W-1:0] half_per_i,
  output logic            step_o
);
  logic [HP_W-1:0] cnt_q;

  assign step_o = (cnt_q == half_per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || step_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_ld_timeout.sv
module cfg_ld_timeout #(
  parameter int TMO_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == TW'(TMO_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // saturates until cleared
  p_tmo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);
endmodule

// File: rtl/cfg_loader_par.sv
module cfg_loader_par
  import cfg_ld_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int HP_W    = 8,
  parameter int TMO_CYC = 500000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rdbk_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic [HP_W-1:0]  half_per_i,
  input  logic             busy_chk_en_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             prog_o,
  output logic             cs_o,
  output logic             wr_o,
  output logic             cclk_o,
  output logic [7:0]       d_o,
  output logic             d_oe_o,
  input  logic [7:0]       d_i,
  input  logic             init_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             active_o,
  output logic             ok_o,
  output logic             fail_o,
  output logic [1:0]       err_o
);
  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [7:0]       dat_q, dat_d, rd_q, rd_d;
  ld_err_e          err_q, err_d;
  logic             ok_q, ok_d, fail_q, fail_d, rdv_q, rdv_d;
  logic             tmr_clr, tmo, stp;

  cfg_ld_pacer #(.HP_W(HP_W)) u_pacer (
    .clk_i, .rst_ni, .restart_i(state_d != state_q),
    .half_per_i, .step_o(stp)
  );

  cfg_ld_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .expired_o(tmo)
  );

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    dat_d   = dat_q;
    rd_d    = rd_q;
    err_d   = err_q;
    ok_d    = 1'b0;
    fail_d  = 1'b0;
    rdv_d   = 1'b0;
    tmr_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PROG; rem_d = byte_cnt_i; err_d = ERR_NONE;
        end else if (rdbk_i) begin
          state_d = ST_RB_CS; rem_d = byte_cnt_i; err_d = ERR_NONE;
        end
      end
      ST_PROG: if (stp) begin state_d = ST_W_INIT; tmr_clr = 1'b1; end
      ST_W_INIT: begin
        if (!init_i && !busy_i) state_d = ST_S_WR;
        else if (tmo) begin state_d = ST_ABORT; err_d = ERR_INIT; end
      end
      ST_S_WR:  if (stp) state_d = ST_S_CS;
      ST_S_CS:  if (stp) state_d = ST_S_CLK;
      ST_S_CLK: if (stp) state_d = (rem_q == '0) ? ST_E_CS : ST_STREAM;
      ST_STREAM: if (s_valid_i) begin
        dat_d = s_data_i; rem_d = rem_q - 1'b1; tmr_clr = 1'b1; state_d = ST_C_LO;
      end
      ST_C_LO: if (stp) state_d = ST_C_HI;
      ST_C_HI: if (stp) begin
        if (busy_chk_en_i && busy_i) begin
          if (tmo) begin state_d = ST_ABORT; err_d = ERR_BUSY; end
          else state_d = ST_C_LO;            // re-clock the held byte
        end else state_d = (rem_q == '0) ? ST_E_CS : ST_STREAM;
      end
      ST_E_CS: if (stp) state_d = ST_E_WR;
      ST_E_WR: if (stp) begin state_d = ST_DN_CHK; tmr_clr = 1'b1; end
      ST_DN_CHK: begin
        if (done_i) begin state_d = ST_IDLE; ok_d = 1'b1; end
        else if (tmo) begin state_d = ST_ABORT; err_d = ERR_DONE; end
        else state_d = ST_DN_LO;
      end
      ST_DN_LO: if (stp) state_d = ST_DN_HI;
      ST_DN_HI: if (stp) state_d = ST_DN_CHK;
      ST_ABORT: begin state_d = ST_IDLE; fail_d = 1'b1; end
      ST_RB_CS: if (stp) state_d = (rem_q == '0) ? ST_RB_END : ST_RB_LO;
      ST_RB_LO: if (stp) state_d = ST_RB_HI;
      ST_RB_HI: if (stp) begin
        rd_d = d_i; rdv_d = 1'b1; rem_d = rem_q - 1'b1;
        state_d = (rem_q == CNT_W'(1)) ? ST_RB_END : ST_RB_LO;
      end
      ST_RB_END: if (stp) begin state_d = ST_IDLE; ok_d = 1'b1; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      dat_q   <= '0;
      rd_q    <= '0;
      err_q   <= ERR_NONE;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      dat_q   <= dat_d;
      rd_q    <= rd_d;
      err_q   <= err_d;
      ok_q    <= ok_d;
      fail_q  <= fail_d;
      rdv_q   <= rdv_d;
    end
  end

  assign prog_o     = (state_q == ST_PROG);
  assign cs_o       = state_q inside {ST_S_CS, ST_S_CLK, ST_STREAM, ST_C_LO, ST_C_HI,
                                      ST_RB_CS, ST_RB_LO, ST_RB_HI};
  assign wr_o       = state_q inside {ST_S_WR, ST_S_CS, ST_S_CLK, ST_STREAM, ST_C_LO,
                                      ST_C_HI, ST_E_CS};
  assign cclk_o     = !(state_q inside {ST_C_LO, ST_DN_LO, ST_RB_LO});
  assign d_oe_o     = wr_o;
  assign d_o        = dat_q;
  assign s_ready_o  = (state_q == ST_STREAM);
  assign rd_data_o  = rd_q;
  assign rd_valid_o = rdv_q;
  assign active_o   = (state_q != ST_IDLE);
  assign ok_o       = ok_q;
  assign fail_o     = fail_q;
  assign err_o      = err_q;

  p_prog_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> (!cs_o && !wr_o));
  p_wr_lead_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_o) && wr_o) |-> $past(wr_o));
  p_ready_scope_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (cs_o && wr_o && cclk_o));
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cclk_o) && wr_o) |-> $stable(d_o));
  p_cs_lead_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> !cs_o);
  p_verdict_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (err_o != 2'd0 && !ok_o && !cs_o && !wr_o));
  p_rb_nowr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!wr_o && !d_oe_o));
endmodule

// File: tb/tb_cfg_loader_par.sv
module tb_cfg_loader_par;
  localparam int CW = 8, HW = 4, TMO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, rdbk = 0, busy_chk = 0, s_valid = 0;
  logic [CW-1:0] byte_cnt = '0;
  logic [HW-1:0] half_per = '0;
  logic [7:0] s_data = '0, d_i = '0;
  logic init_i = 0, busy_i = 0;
  logic s_ready, prog, cs, wr, cclk, d_oe, rd_valid, active, ok, fail, done_i;
  logic [7:0] d_o, rd_data;
  logic [1:0] err;

  cfg_loader_par #(.CNT_W(CW), .HP_W(HW), .TMO_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rdbk_i(rdbk), .byte_cnt_i(byte_cnt),
    .half_per_i(half_per), .busy_chk_en_i(busy_chk), .s_data_i(s_data), .s_valid_i(s_valid),
    .s_ready_o(s_ready), .prog_o(prog), .cs_o(cs), .wr_o(wr), .cclk_o(cclk), .d_o(d_o),
    .d_oe_o(d_oe), .d_i(d_i), .init_i(init_i), .busy_i(busy_i), .done_i(done_i),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .active_o(active), .ok_o(ok),
    .fail_o(fail), .err_o(err)
  );

  int checks = 0, errs = 0, wd = 0;

  task automatic check(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i); return 8'((i * 29 + 3) & 255); endfunction
  function automatic logic [7:0] rbf(input int i); return 8'((i * 37 + 5) & 255); endfunction

  // scenario knobs (written only by the main process)
  int k_n, k_bafter, k_blen, k_dn, k_ilat, k_istk, k_gap;
  logic clr_m = 0;

  // target model, clocked by the configuration clock
  logic [7:0] cap [0:15];
  int cap_n, wr_edges, post_edges, busy_cnt, rb_src;
  always @(posedge cclk or posedge clr_m) begin
    if (clr_m) begin
      cap_n = 0; wr_edges = 0; post_edges = 0; busy_cnt = 0; rb_src = 0;
      busy_i = 1'b0; d_i = 8'h00;
    end else if (cs && wr) begin
      wr_edges++;
      if (busy_cnt > 0) busy_cnt--;
      else begin
        if (cap_n < 16) cap[cap_n] = d_o;
        cap_n++;
        if (k_bafter != 0 && cap_n == k_bafter) busy_cnt = k_blen;
      end
      busy_i = (busy_cnt > 0);
    end else if (!cs && !wr) post_edges++;
    else if (cs && !wr) begin d_i = rbf(rb_src); rb_src++; end
  end
  assign done_i = (post_edges >= k_dn);

  // feeder, init model and pin monitors, all at the falling edge
  int cyc, feed_idx, init_cnt;
  bit feed_take, gap_tog;
  int prog_hi, prog_fall, wr_rise, cs_rise, cs_fall, wr_fall, rdy_viol, rb_viol;
  int lo_run, lo_min, lo_max, rb_n;
  logic p_prog, p_wr, p_cs, p_cclk;
  logic [7:0] rb_got [0:15];
  always @(negedge clk) begin
    cyc++;
    if (clr_m) begin
      feed_idx = 0; feed_take = 0; init_cnt = 0; prog_hi = 0; prog_fall = -1;
      wr_rise = -1; cs_rise = -1; cs_fall = -1; wr_fall = -1; rdy_viol = 0; rb_viol = 0;
      lo_run = 0; lo_min = 999; lo_max = -1; rb_n = 0;
      p_prog = prog; p_wr = wr; p_cs = cs; p_cclk = cclk;
    end else begin
      if (feed_take) feed_idx++;
      gap_tog = !gap_tog;
      s_valid = (feed_idx < k_n + 2) && !(k_gap != 0 && gap_tog);
      s_data  = pat(feed_idx);
      feed_take = s_valid && s_ready;
      if (prog) init_cnt = k_ilat; else if (init_cnt > 0) init_cnt--;
      if (prog) prog_hi++;
      if (p_prog && !prog) prog_fall = cyc;
      if (!p_wr && wr && wr_rise < 0) wr_rise = cyc;
      if (!p_cs && cs && cs_rise < 0) cs_rise = cyc;
      if (p_cs && !cs && cs_fall < 0) cs_fall = cyc;
      if (p_wr && !wr && wr_fall < 0) wr_fall = cyc;
      if (s_ready && !(cs && wr && cclk)) rdy_viol++;
      if (rdbk_mode && (wr || d_oe)) rb_viol++;
      if (!cclk) lo_run++;
      else if (!p_cclk) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
        lo_run = 0;
      end
      if (rd_valid) begin if (rb_n < 16) rb_got[rb_n] = rd_data; rb_n++; end
      p_prog = prog; p_wr = wr; p_cs = cs; p_cclk = cclk;
    end
    init_i = (k_istk != 0) || (init_cnt > 0);
  end
  logic rdbk_mode = 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic prep(input int n, input int hp);
    k_n = n; byte_cnt = CW'(n); half_per = HW'(hp);
    clr_m = 1; @(negedge clk); @(negedge clk); clr_m = 0;
  endtask

  task automatic wait_end(output int res);
    res = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ok)   begin res = 0; break; end
      if (fail) begin res = 1; break; end
    end
  endtask

  task automatic run_load(input int n, hp, chk, bafter, blen, dn, ilat, istk, gap, exp_err);
    int res;
    k_bafter = bafter; k_blen = blen; k_dn = dn; k_ilat = ilat; k_istk = istk; k_gap = gap;
    busy_chk = chk[0]; rdbk_mode = 0;
    prep(n, hp);
    start = 1; @(negedge clk); start = 0;
    check(err == 2'd0 && active, "R11 start clears code", err, 0);
    wait_end(res);
    check(res == (exp_err != 0 ? 1 : 0), "R11 verdict", res, exp_err != 0);
    check(err == 2'(exp_err), "R3/R7/R10 error code", err, exp_err);
    check(!cs && !wr, "R11 strobes released", {cs, wr}, 0);
    if (exp_err != 0) begin
      repeat (10) @(negedge clk);
      check(err == 2'(exp_err), "R11 code sticky", err, exp_err);
      check(feed_idx <= n, "R13 no excess input", feed_idx, n);
      return;
    end
    check(feed_idx == n, "R13 input bytes taken", feed_idx, n);
    if (!(chk == 0 && bafter != 0)) begin
      check(cap_n == n, "R5 bytes received", cap_n, n);
      for (int i = 0; i < n; i++)
        check(cap[i] == pat(i), "R5 byte order", cap[i], pat(i));
    end
    check(wr_edges == n + ((chk != 0 && bafter != 0) ? blen : 0), "R6 write edges",
          wr_edges, n + ((chk != 0 && bafter != 0) ? blen : 0));
    check(post_edges == dn, "R9 completion pulses", post_edges, dn);
    check(prog_hi == hp + 1, "R2 program width", prog_hi, hp + 1);
    check(wr_rise - prog_fall >= ilat, "R3 init wait", wr_rise - prog_fall, ilat);
    check(wr_rise < cs_rise, "R4 write before select", wr_rise, cs_rise);
    check(cs_fall < wr_fall, "R8 select drops first", cs_fall, wr_fall);
    check(rdy_viol == 0, "R4 ready scope", rdy_viol, 0);
    if (n + dn > 0)
      check(lo_min == hp + 1 && lo_max == hp + 1, "R14 low phase", lo_max, hp + 1);
  endtask

  task automatic run_rb(input int n, hp);
    int res;
    k_bafter = 0; k_blen = 0; k_dn = 0; k_ilat = 0; k_istk = 0; k_gap = 0;
    rdbk_mode = 1;
    prep(n, hp);
    k_n = -2;  // feeder offers nothing
    rdbk = 1; @(negedge clk); rdbk = 0;
    wait_end(res);
    rdbk_mode = 0;
    check(res == 0, "R12 readback ok", res, 0);
    check(rb_n == n, "R12 R13 readback count", rb_n, n);
    for (int i = 0; i < n; i++)
      check(rb_got[i] == rbf(i), "R12 readback byte", rb_got[i], rbf(i));
    check(rb_viol == 0, "R12 write low in readback", rb_viol, 0);
    if (n > 0) check(lo_min == hp + 1 && lo_max == hp + 1, "R14 readback low phase", lo_max, hp + 1);
  endtask

  initial begin
    k_n = 0; k_bafter = 0; k_blen = 0; k_dn = 0; k_ilat = 0; k_istk = 0; k_gap = 0;
    repeat (3) @(negedge clk);
    check(!prog && !cs && !wr && !s_ready && err == 0 && !active, "R1 reset state",
          {prog, cs, wr, s_ready, active}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!prog && !cs && !wr && !s_ready && err == 0 && !active, "R1 after release",
          {prog, cs, wr, s_ready, active}, 0);
    // sweep phase length and byte count
    for (int hp = 0; hp < 4; hp++)
      for (int j = 0; j < 3; j++) begin
        int n = (j == 0) ? 0 : (j == 1) ? 1 : 5;
        run_load(n, hp, 1, 0, 0, hp, 5, 0, j & 1, 0);
      end
    // busy stall, checked and ignored
    run_load(4, 1, 1, 2, 3, 2, 5, 0, 0, 0);
    run_load(4, 0, 1, 4, 2, 1, 3, 0, 1, 0);
    run_load(4, 1, 0, 2, 3, 2, 5, 0, 0, 0);
    run_load(3, 0, 1, 0, 0, 0, 20, 0, 0, 0);
    // timeouts
    run_load(2, 1, 0, 0, 0, 0, 0, 1, 0, 1);
    run_load(3, 1, 1, 2, 100000, 0, 2, 0, 0, 2);
    run_load(2, 0, 1, 0, 0, 100000, 2, 0, 0, 3);
    // readback sweep (also clears the sticky code)
    for (int hp = 0; hp < 3; hp++) begin
      run_rb(0, hp); run_rb(3, hp); run_rb(6, hp);
    end
    check(err == 2'd0, "R11 readback clears code", err, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule